// File: doc/BRIEF.md
# Up/Down Timer with Edge Capture

This block is a 16-bit counter/timer for a microcontroller-style peripheral set. It counts up or down on a count event and copies its running value into a 16-bit capture register when the external capture input falls. The count event is either an internal tick strobe or a falling edge on an external event pin. A shared flag records wrap-around in either direction. A second flag records captures. The two flags drive one maskable interrupt line.

Software reaches the block through a small byte-wide register port. Writes take effect at the clock edge. Reads return data one cycle after the address is presented. The counter bytes can be written to preload a value. Both external pins pass through a two-flop synchroniser before their falling edges are detected. A falling edge is therefore acted on at the third rising clock edge after the pin goes low.

Top module: `updn_capture_timer`

## Requirements
- R1: After synchronous reset, every register reads 0, both flags are clear and `irq` is 0.
- R2: Register map: address 0 is control, addresses 1 and 2 are counter low and high bytes, and addresses 3 and 4 are capture low and high bytes. The control fields are: bit0 mode select, bit1 run, bit2 capture enable, bit3 external source, bit4 count down, bit6 capture flag and bit7 wrap flag. Reads appear on `rdata` one cycle after `addr`. With the direction bit 0, each count event adds one. Stepping from 0xFFFF to 0x0000 sets the wrap flag.
- R3: With the direction bit (bit4) set to 1, each count event subtracts one. Stepping from 0x0000 to 0xFFFF sets the same wrap flag (bit7).
- R4: When the mode is active and capture enable (bit2) is 1, a falling edge on `cap_in` loads the counter into the capture register and sets the capture flag (bit6). This happens at the third rising clock edge after the pin falls.
- R5: While capture enable is 0, falling edges on `cap_in` leave the capture register and the capture flag unchanged.
- R6: The block counts and captures only while both mode select (bit0) and run (bit1) are 1. Otherwise the counter holds its value.
- R7: With the source bit (bit3) at 0, each cycle with `tick` high is one count event. With bit3 at 1, `tick` is ignored and each synchronised falling edge of `ev_in` is one count event.
- R8: Both flags stay set until software writes 0 to the flag's bit at address 0. Writing 1 to a flag bit changes nothing. If a flag is set and cleared in the same cycle, it ends up set.
- R9: When a capture and a count event happen in the same cycle, the capture register receives the counter value from before that count.
- R10: `irq` is a register that follows `irq_en` AND (wrap flag OR capture flag), one cycle later.
- R11: A single falling edge on `cap_in` causes exactly one capture, however long the pin then stays low.
- R12: A write to a counter byte replaces that byte. In that cycle it overrides any count event and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| tick | input | 1 | Internal count strobe |
| ev_in | input | 1 | External event pin (asynchronous) |
| cap_in | input | 1 | External capture pin (asynchronous) |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench forces two pairs of functions to coincide.

- **Capture with count.** `cap_in` is dropped on the same cycle that `tick` rises with the counter at zero. The capture then lands on the third count edge. The captured value must be 2, the pre-count value, not 3.
- **Flag set with software clear.** A write of 0 to the capture-flag bit is timed for the exact edge at which a capture arrives. The flag must read back as set.

A behavioural model checks every cycle of both cases.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTL_SEL   = 0;
  localparam int CTL_RUN   = 1;
  localparam int CTL_CAPEN = 2;
  localparam int CTL_EXT   = 3;
  localparam int CTL_DOWN  = 4;
  localparam int CTL_CAPF  = 6;
  localparam int CTL_OVF   = 7;
  localparam int CFG_W     = 5;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);
  logic [STAGES-1:0] sh;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      last <= 1'b1;
    end else begin
      sh   <= {sh[STAGES-2:0], din};
      last <= sh[STAGES-1];
    end
  end

  assign fall = last & ~sh[STAGES-1];
endmodule

// File: rtl/tmr_updn_counter.sv
module tmr_updn_counter #(
  parameter int W  = 16,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic            down,
  input  logic [W/DW-1:0] byte_we,
  input  logic [DW-1:0]   wdata,
  output logic [W-1:0]    cnt,
  output logic            wrap
);
  localparam int NB = W / DW;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (|byte_we) begin
      for (int i = 0; i < NB; i++)
        if (byte_we[i]) cnt[i*DW +: DW] <= wdata;
    end else if (step) begin
      cnt <= down ? cnt - 1'b1 : cnt + 1'b1;
    end
  end

  always_comb begin
    wrap = step & ~(|byte_we) & (down ? (cnt == '0) : (&cnt));
  end
endmodule

// File: rtl/tmr_capture_reg.sv
module tmr_capture_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/updn_capture_timer.sv
module updn_capture_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              tick,
  input  logic              ev_in,
  input  logic              cap_in,
  input  logic              irq_en,
  output logic              irq
);
  localparam int NB     = CNT_W / DATA_W;
  localparam int A_CNT0 = 1;
  localparam int A_CAP0 = 1 + NB;

  logic [CFG_W-1:0]  cfg;
  logic              ovf_f, cap_f;
  logic              ev_fall, cap_fall;
  logic              mode_on, step, cap_load, wrap, wr_ctl;
  logic [NB-1:0]     byte_we;
  logic [CNT_W-1:0]  cnt, cap_q;
  logic [DATA_W-1:0] rd_next;
  int                a_i;

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_ev_sync (
    .clk(clk), .rst(rst), .din(ev_in), .fall(ev_fall));

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_cap_sync (
    .clk(clk), .rst(rst), .din(cap_in), .fall(cap_fall));

  always_comb begin
    a_i      = int'(addr);
    wr_ctl   = wr_en && (a_i == 0);
    mode_on  = cfg[CTL_SEL] & cfg[CTL_RUN];
    step     = mode_on & (cfg[CTL_EXT] ? ev_fall : tick);
    cap_load = mode_on & cfg[CTL_CAPEN] & cap_fall;
    for (int i = 0; i < NB; i++)
      byte_we[i] = wr_en && (a_i == A_CNT0 + i);
  end

  tmr_updn_counter #(.W(CNT_W), .DW(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .down(cfg[CTL_DOWN]),
    .byte_we(byte_we), .wdata(wdata), .cnt(cnt), .wrap(wrap));

  tmr_capture_reg #(.W(CNT_W)) u_cap (
    .clk(clk), .rst(rst), .load(cap_load), .din(cnt), .q(cap_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg   <= '0;
      ovf_f <= 1'b0;
      cap_f <= 1'b0;
    end else begin
      if (wr_ctl) cfg <= wdata[CFG_W-1:0];
      ovf_f <= wrap     | (ovf_f & ~(wr_ctl & ~wdata[CTL_OVF]));
      cap_f <= cap_load | (cap_f & ~(wr_ctl & ~wdata[CTL_CAPF]));
    end
  end

  always_comb begin
    rd_next = '0;
    if (a_i == 0) begin
      rd_next[CFG_W-1:0] = cfg;
      rd_next[CTL_CAPF]  = cap_f;
      rd_next[CTL_OVF]   = ovf_f;
    end
    for (int i = 0; i < NB; i++) begin
      if (a_i == A_CNT0 + i) rd_next = cnt[i*DATA_W +: DATA_W];
      if (a_i == A_CAP0 + i) rd_next = cap_q[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      rdata <= rd_next;
      irq   <= irq_en & (ovf_f | cap_f);
    end
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  irq,
  input logic                  irq_en,
  input logic                  ovf_f,
  input logic                  cap_f,
  input logic [CFG_W-1:0]      cfg,
  input logic                  wr_ctl,
  input logic [DATA_W-1:0]     wdata,
  input logic [CNT_W-1:0]      cnt,
  input logic [CNT_W-1:0]      cap_q,
  input logic                  cap_load,
  input logic [CNT_W/DATA_W-1:0] byte_we
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk) rst |=> !irq);

  // R10
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_en && (ovf_f || cap_f)) |=> irq);

  // R10
  irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !(irq_en && (ovf_f || cap_f)) |=> !irq);

  // R5
  no_cap_off_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg[CTL_CAPEN] |=> $stable(cap_q));

  // R6
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!(cfg[CTL_SEL] && cfg[CTL_RUN]) && !(|byte_we)) |=> $stable(cnt));

  // R8
  capf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_f && !(wr_ctl && !wdata[CTL_CAPF])) |=> cap_f);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_f && !(wr_ctl && !wdata[CTL_OVF])) |=> ovf_f);

  // R9
  cap_pre_chk: assert property (@(posedge clk) disable iff (rst)
    cap_load |=> (cap_q == $past(cnt)));
endmodule

bind updn_capture_timer tmr_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .irq_en(irq_en), .ovf_f(ovf_f),
  .cap_f(cap_f), .cfg(cfg), .wr_ctl(wr_ctl), .wdata(wdata), .cnt(cnt),
  .cap_q(cap_q), .cap_load(cap_load), .byte_we(byte_we));

// File: tb/tb_updn_capture_timer.sv
module tb_updn_capture_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tick = 1'b0, ev_in = 1'b1, cap_in = 1'b1, irq_en = 1'b0;
  logic       irq;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  updn_capture_timer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tick(tick), .ev_in(ev_in), .cap_in(cap_in),
    .irq_en(irq_en), .irq(irq));

  // behavioural reference model
  logic [4:0]  m_cfg;
  logic        m_ovf, m_capf, m_irq;
  logic [15:0] m_cnt, m_cap;
  logic [7:0]  m_rd;
  logic [2:0]  c_h, e_h;
  int          m_ra;

  always @(posedge clk) begin
    logic act, evt, capt, wrapped;
    logic [7:0] nrd;
    int a;
    a = int'(addr);
    if (rst) begin
      m_cfg = 0; m_ovf = 0; m_capf = 0; m_irq = 0; m_cnt = 0; m_cap = 0;
      m_rd = 0; c_h = 3'b111; e_h = 3'b111; m_ra = 0;
    end else begin
      case (a)
        0: nrd = {m_ovf, m_capf, 1'b0, m_cfg};
        1: nrd = m_cnt[7:0];
        2: nrd = m_cnt[15:8];
        3: nrd = m_cap[7:0];
        4: nrd = m_cap[15:8];
        default: nrd = 8'h00;
      endcase
      m_irq = irq_en && (m_ovf || m_capf);
      act  = m_cfg[0] && m_cfg[1];
      evt  = act && (m_cfg[3] ? (e_h[2] && !e_h[1]) : tick);
      capt = act && m_cfg[2] && c_h[2] && !c_h[1];
      wrapped = 0;
      if (capt) m_cap = m_cnt;
      if (wr_en && a == 1) m_cnt[7:0] = wdata;
      else if (wr_en && a == 2) m_cnt[15:8] = wdata;
      else if (evt) begin
        if (m_cfg[4]) begin wrapped = (m_cnt == 16'h0000); m_cnt = m_cnt - 1; end
        else begin wrapped = (m_cnt == 16'hFFFF); m_cnt = m_cnt + 1; end
      end
      if (wr_en && a == 0) begin
        if (!wdata[7]) m_ovf = 0;
        if (!wdata[6]) m_capf = 0;
        m_cfg = wdata[4:0];
      end
      if (wrapped) m_ovf = 1;
      if (capt) m_capf = 1;
      c_h = {c_h[1:0], cap_in};
      e_h = {e_h[1:0], ev_in};
      m_rd = nrd;
      m_ra = a;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(m_ra == 0 ? "R8" : (m_ra < 3 ? "R2" : "R4"), rdata, m_rd);
      chk("R10", irq, m_irq);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; addr = 3'(a); wdata = 8'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); wr_en = 0; addr = 3'(a);
    @(negedge clk); v = rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic pulse_ev();
    @(negedge clk); ev_in = 0;
    repeat (3) @(negedge clk);
    ev_in = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_cap();
    @(negedge clk); cap_in = 0;
    repeat (4) @(negedge clk);
    cap_in = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int v;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    for (int a = 0; a < 5; a++) begin rd(a, v); chk("R1", v, 0); end
    chk("R1", irq, 0);
    // R2 counting up
    wr(0, 8'h03); ticks(5);
    rd(1, v); chk("R2", v, 5);
    rd(2, v); chk("R2", v, 0);
    // R12 preload near top, then wrap
    wr(0, 8'h00); wr(1, 8'hFE); wr(2, 8'hFF);
    rd(1, v); chk("R12", v, 8'hFE);
    wr(0, 8'h03); ticks(3);
    rd(1, v); chk("R2", v, 1);
    rd(0, v); chk("R2", v, 8'h83);
    // R10 interrupt
    @(negedge clk); irq_en = 1;
    idle(2); chk("R10", irq, 1);
    irq_en = 0;
    // R8 clear by writing 0
    wr(0, 8'h03); rd(0, v); chk("R8", v, 8'h03);
    // R3 count down through zero
    wr(0, 8'h00); wr(1, 2); wr(2, 0); wr(0, 8'h13); ticks(3);
    rd(1, v); chk("R3", v, 8'hFF);
    rd(2, v); chk("R3", v, 8'hFF);
    rd(0, v); chk("R3", v, 8'h93);
    // R6 mode gating
    wr(0, 8'h02); ticks(4); rd(1, v); chk("R6", v, 8'hFF);
    wr(0, 8'h05); pulse_cap(); ticks(2);
    rd(3, v); chk("R6", v, 0);
    rd(0, v); chk("R6", v, 8'h05);
    // R7 external source
    wr(1, 0); wr(2, 0); wr(0, 8'h0B);
    ticks(5);
    rd(1, v); chk("R7", v, 0);
    pulse_ev(); pulse_ev(); pulse_ev();
    rd(1, v); chk("R7", v, 3);
    // R4 capture
    wr(0, 8'h00); wr(1, 8'h34); wr(2, 8'h12); wr(0, 8'h07);
    pulse_cap();
    rd(3, v); chk("R4", v, 8'h34);
    rd(4, v); chk("R4", v, 8'h12);
    rd(0, v); chk("R4", v, 8'h47);
    // R11 one capture per edge
    wr(0, 8'h07);
    @(negedge clk); cap_in = 0;
    idle(4); wr(0, 8'h07); idle(6);
    rd(0, v); chk("R11", v, 8'h07);
    @(negedge clk); cap_in = 1; idle(4);
    // R5 capture disabled
    wr(0, 8'h00); wr(1, 8'h99); wr(0, 8'h03);
    pulse_cap();
    rd(3, v); chk("R5", v, 8'h34);
    rd(0, v); chk("R5", v, 8'h03);
    // R9 capture coincides with count
    wr(0, 8'h00); wr(1, 0); wr(2, 0); wr(0, 8'h07);
    @(negedge clk); tick = 1; cap_in = 0;
    idle(5); tick = 0; cap_in = 1; idle(4);
    rd(3, v); chk("R9", v, 2);
    rd(4, v); chk("R9", v, 0);
    // R8 set beats clear
    wr(0, 8'h07);
    @(negedge clk); cap_in = 0;
    @(negedge clk);
    @(negedge clk); wr_en = 1; addr = 0; wdata = 8'h07;
    @(negedge clk); wr_en = 0;
    rd(0, v); chk("R8", v, 8'h47);
    // R8 writing 1 keeps flag and does not set the other
    wr(0, 8'hC7); rd(0, v); chk("R8", v, 8'h47);
    @(negedge clk); cap_in = 1; irq_en = 1;
    idle(2); chk("R10", irq, 1);
    wr(0, 8'h07); idle(2); chk("R10", irq, 0);
    idle(4);
    finish_run();
  end
endmodule